// File: doc/BRIEF.md
# Shared-Row Multi-Port Word Memory

This block is a synchronous on-chip memory organised as rows of words. It serves several access ports in the same clock cycle, on one condition: every port works inside the same row. Port 0 carries the full address, made of a row part and a column part. Every other port contributes only its column part. Whatever those ports place in their row bits is discarded, and the row named by port 0 is used instead. The result is one row decoder and one row read-out, with a column selector replicated per port. Any mix of reads and writes across the ports is accepted in a cycle.

Each port has a request-valid strobe, a write flag, an address and write data. Read results come back on a response-valid strobe with the data, one clock after the request. There is no back-pressure: the block has no ready output and accepts every request in the cycle it is presented. A response is shown for exactly one cycle, and the consumer must take it then. Two ports may read the same column. If two active ports name the same column and at least one of them writes, the block raises a collision flag one cycle later. The lowest-numbered writing port wins, and the colliding read returns an unspecified word. PORTS must not exceed WORDS_PER_ROW, and ROWS and WORDS_PER_ROW are powers of two.

Top module: `shared_row_mem`

## Requirements
- R1: The row used by every port in a cycle is bits [AW-1:COL_W] of port 0's address. The row bits of ports 1 and above have no effect. Each port's column is the low COL_W bits of its own address slice, and port p's slice is req_addr[p*AW +: AW].
- R2: A read request on port p (req_valid high, req_write low) raises rsp_valid[p] on the following clock. rsp_valid[p] is low in every other cycle.
- R3: A write stores req_wdata at the clock edge, and any read presented in a later cycle returns the stored word.
- R4: In one cycle, every port is served together when the ports name different columns, whatever the mix of reads and writes.
- R5: col_clash is high in the cycle after a cycle in which two enabled ports named the same column with at least one of them writing, and low otherwise. Two reads of the same column raise no flag, and both return the word.
- R6: When several ports write the same column in one cycle, the word stored is the one from the lowest-numbered writing port.
- R7: While reset is asserted, rsp_valid, rsp_rdata and col_clash are all zero. The stored words are not cleared.
- R8: A port's rsp_rdata keeps its previous value in every cycle in which that port's rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | PORTS | Per-port request strobe |
| req_write | input | PORTS | Per-port write flag (1 write, 0 read) |
| req_addr | input | PORTS*AW | Per-port address {row, column}; only port 0's row is used |
| req_wdata | input | PORTS*WIDTH | Per-port write word |
| rsp_valid | output | PORTS | Per-port read response strobe |
| rsp_rdata | output | PORTS*WIDTH | Per-port read word |
| col_clash | output | 1 | Same-column collision with a write in the previous cycle |

## Verification
A wrongly stored or wrongly routed word becomes visible on rsp_rdata the cycle after the first later read of that address. Row forcing is covered the same way: if it were broken, a secondary port would return a word from the row its own ignored bits named. A fault in the collision logic or the write priority shows on col_clash, or in the word read back, within one or two cycles of the colliding request. The bench fills the array first and compares every output on every clock, so a fault is reported on its first observable cycle.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } srm_op_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/srm_port_decode.sv
module srm_port_decode
  import srm_pkg::*;
#(
  parameter int WORDS_PER_ROW = 8,
  localparam int COL_W = idx_w(WORDS_PER_ROW)
) (
  input  logic                     en,
  input  logic                     we,
  input  logic [COL_W-1:0]         col,
  output srm_op_e                  op,
  output logic [WORDS_PER_ROW-1:0] col_hot
);

  always_comb begin
    if (!en)     op = OP_IDLE;
    else if (we) op = OP_WRITE;
    else         op = OP_READ;
  end

  always_comb begin
    col_hot = '0;
    if (en) col_hot[col] = 1'b1;
  end

endmodule

// File: rtl/srm_conflict.sv
module srm_conflict
  import srm_pkg::*;
#(
  parameter int WORDS_PER_ROW = 8,
  parameter int PORTS         = 2,
  localparam int COL_W = idx_w(WORDS_PER_ROW)
) (
  input  logic [PORTS-1:0]       en,
  input  logic [PORTS-1:0]       we,
  input  logic [PORTS*COL_W-1:0] cols,
  output logic                   clash
);

  logic [PORTS*PORTS-1:0] pair_hit;

  for (genvar a = 0; a < PORTS; a++) begin : g_a
    for (genvar b = 0; b < PORTS; b++) begin : g_b
      if (b > a) begin : g_pair
        assign pair_hit[a*PORTS+b] = en[a] && en[b] && (we[a] || we[b]) &&
                                     (cols[a*COL_W +: COL_W] == cols[b*COL_W +: COL_W]);
      end else begin : g_none
        assign pair_hit[a*PORTS+b] = 1'b0;
      end
    end
  end

  assign clash = |pair_hit;

endmodule

// File: rtl/srm_row_array.sv
module srm_row_array
  import srm_pkg::*;
#(
  parameter int ROWS          = 256,
  parameter int WORDS_PER_ROW = 8,
  parameter int WIDTH         = 8,
  parameter int PORTS         = 2,
  localparam int ROW_W  = idx_w(ROWS),
  localparam int LINE_W = WORDS_PER_ROW * WIDTH
) (
  input  logic                             clk,
  input  logic [ROW_W-1:0]                 row,
  input  logic [PORTS*WORDS_PER_ROW-1:0]   wr_hot,
  input  logic [PORTS*WIDTH-1:0]           wdata,
  output logic [LINE_W-1:0]                row_line
);

  logic [LINE_W-1:0] store [ROWS];
  logic [WORDS_PER_ROW-1:0] col_we;
  logic [LINE_W-1:0]        col_wd;

  // per column: scan ports from highest to lowest so the lowest writer is kept
  for (genvar c = 0; c < WORDS_PER_ROW; c++) begin : g_col
    always_comb begin
      col_we[c]                 = 1'b0;
      col_wd[c*WIDTH +: WIDTH]  = '0;
      for (int k = PORTS - 1; k >= 0; k--) begin
        if (wr_hot[k*WORDS_PER_ROW + c]) begin
          col_we[c]                = 1'b1;
          col_wd[c*WIDTH +: WIDTH] = wdata[k*WIDTH +: WIDTH];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < WORDS_PER_ROW; c++) begin
      if (col_we[c]) store[row][c*WIDTH +: WIDTH] <= col_wd[c*WIDTH +: WIDTH];
    end
  end

  assign row_line = store[row];

endmodule

// File: rtl/srm_read_stage.sv
module srm_read_stage
  import srm_pkg::*;
#(
  parameter int WORDS_PER_ROW = 8,
  parameter int WIDTH         = 8,
  parameter int PORTS         = 2,
  localparam int COL_W  = idx_w(WORDS_PER_ROW),
  localparam int LINE_W = WORDS_PER_ROW * WIDTH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PORTS-1:0]         rd_req,
  input  logic [PORTS*COL_W-1:0]   cols,
  input  logic [LINE_W-1:0]        row_line,
  input  logic                     clash_in,
  output logic [PORTS-1:0]         rvalid,
  output logic [PORTS*WIDTH-1:0]   rdata,
  output logic                     clash_q
);

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [COL_W-1:0] pcol;
    assign pcol = cols[p*COL_W +: COL_W];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rvalid[p]              <= 1'b0;
        rdata[p*WIDTH +: WIDTH] <= '0;
      end else begin
        rvalid[p] <= rd_req[p];
        if (rd_req[p]) rdata[p*WIDTH +: WIDTH] <= row_line[pcol*WIDTH +: WIDTH];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) clash_q <= 1'b0;
    else        clash_q <= clash_in;
  end

endmodule

// File: rtl/shared_row_mem.sv
module shared_row_mem
  import srm_pkg::*;
#(
  parameter int ROWS          = 256,
  parameter int WORDS_PER_ROW = 8,
  parameter int WIDTH         = 8,
  parameter int PORTS         = 2,
  localparam int ROW_W  = idx_w(ROWS),
  localparam int COL_W  = idx_w(WORDS_PER_ROW),
  localparam int AW     = ROW_W + COL_W,
  localparam int LINE_W = WORDS_PER_ROW * WIDTH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PORTS-1:0]       req_valid,
  input  logic [PORTS-1:0]       req_write,
  input  logic [PORTS*AW-1:0]    req_addr,
  input  logic [PORTS*WIDTH-1:0] req_wdata,
  output logic [PORTS-1:0]       rsp_valid,
  output logic [PORTS*WIDTH-1:0] rsp_rdata,
  output logic                   col_clash
);

  logic [ROW_W-1:0]               shared_row;
  logic [PORTS*COL_W-1:0]         cols;
  logic [PORTS-1:0]               rd_req;
  logic [PORTS*WORDS_PER_ROW-1:0] wr_hot;
  logic [LINE_W-1:0]              row_line;
  logic                           clash_now;

  // only port 0 drives the row decoder
  assign shared_row = req_addr[AW-1:COL_W];

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    srm_op_e                  op;
    logic [WORDS_PER_ROW-1:0] hot;

    assign cols[p*COL_W +: COL_W] = req_addr[p*AW +: COL_W];

    srm_port_decode #(.WORDS_PER_ROW(WORDS_PER_ROW)) u_dec (
      .en      (req_valid[p]),
      .we      (req_write[p]),
      .col     (req_addr[p*AW +: COL_W]),
      .op      (op),
      .col_hot (hot)
    );

    assign rd_req[p] = (op == OP_READ);
    assign wr_hot[p*WORDS_PER_ROW +: WORDS_PER_ROW] = (op == OP_WRITE) ? hot : '0;
  end

  srm_conflict #(.WORDS_PER_ROW(WORDS_PER_ROW), .PORTS(PORTS)) u_conf (
    .en    (req_valid),
    .we    (req_write),
    .cols  (cols),
    .clash (clash_now)
  );

  srm_row_array #(
    .ROWS(ROWS), .WORDS_PER_ROW(WORDS_PER_ROW), .WIDTH(WIDTH), .PORTS(PORTS)
  ) u_array (
    .clk      (clk),
    .row      (shared_row),
    .wr_hot   (wr_hot),
    .wdata    (req_wdata),
    .row_line (row_line)
  );

  srm_read_stage #(
    .WORDS_PER_ROW(WORDS_PER_ROW), .WIDTH(WIDTH), .PORTS(PORTS)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .cols     (cols),
    .row_line (row_line),
    .clash_in (clash_now),
    .rvalid   (rsp_valid),
    .rdata    (rsp_rdata),
    .clash_q  (col_clash)
  );

endmodule

// File: rtl/srm_checker.sv
module srm_checker
  import srm_pkg::*;
#(
  parameter int ROWS          = 256,
  parameter int WORDS_PER_ROW = 8,
  parameter int WIDTH         = 8,
  parameter int PORTS         = 2,
  localparam int ROW_W = idx_w(ROWS),
  localparam int COL_W = idx_w(WORDS_PER_ROW),
  localparam int AW    = ROW_W + COL_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [PORTS-1:0]       req_valid,
  input logic [PORTS-1:0]       req_write,
  input logic [PORTS*AW-1:0]    req_addr,
  input logic [PORTS*WIDTH-1:0] req_wdata,
  input logic [PORTS-1:0]       rsp_valid,
  input logic [PORTS*WIDTH-1:0] rsp_rdata,
  input logic                   col_clash
);

  for (genvar i = 0; i < PORTS; i++) begin : g_p
    assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && !req_write[i]) |=> rsp_valid[i]);

    assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid[i] && !req_write[i]) |=> !rsp_valid[i]);

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid[i] |-> $stable(rsp_rdata[i*WIDTH +: WIDTH]));

    for (genvar j = i + 1; j < PORTS; j++) begin : g_q
      assert_clash_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[i] && req_valid[j] && (req_write[i] || req_write[j]) &&
         req_addr[i*AW +: COL_W] == req_addr[j*AW +: COL_W]) |=> col_clash);
    end
  end

  assert_clash_needs_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req_valid) < 2) |=> !col_clash);

  assert_clash_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_write == '0) |=> !col_clash);

endmodule

bind shared_row_mem srm_checker #(
  .ROWS(ROWS), .WORDS_PER_ROW(WORDS_PER_ROW), .WIDTH(WIDTH), .PORTS(PORTS)
) u_srm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .col_clash (col_clash)
);

// File: tb/tb_shared_row_mem.sv
module tb_shared_row_mem;
  localparam int ROWS  = 256;
  localparam int WPR   = 8;
  localparam int WIDTH = 8;
  localparam int PORTS = 2;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(WPR);
  localparam int AW    = ROW_W + COL_W;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [PORTS-1:0]       req_valid = '0;
  logic [PORTS-1:0]       req_write = '0;
  logic [PORTS*AW-1:0]    req_addr = '0;
  logic [PORTS*WIDTH-1:0] req_wdata = '0;
  logic [PORTS-1:0]       rsp_valid;
  logic [PORTS*WIDTH-1:0] rsp_rdata;
  logic                   col_clash;

  always #10 clk = ~clk;

  shared_row_mem #(.ROWS(ROWS), .WORDS_PER_ROW(WPR), .WIDTH(WIDTH), .PORTS(PORTS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .col_clash(col_clash));

  int compared = 0;
  int mismatched = 0;

  logic [WIDTH-1:0] model [ROWS*WPR];
  bit               op_v  [PORTS];
  bit               op_w  [PORTS];
  int               op_c  [PORTS];
  int               op_rb [PORTS];
  logic [WIDTH-1:0] op_d  [PORTS];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint got, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic clear_ops();
    for (int k = 0; k < PORTS; k++) begin
      op_v[k] = 0; op_w[k] = 0; op_c[k] = 0; op_rb[k] = 0; op_d[k] = '0;
    end
  endtask

  // drives one cycle of requests at a negedge, updates the model,
  // then compares every output at the following negedge
  task automatic issue(input int row, input string tag);
    logic [WIDTH-1:0] prev  [PORTS];
    logic [WIDTH-1:0] exp_d [PORTS];
    bit               known [PORTS];
    bit               exp_c;
    for (int k = 0; k < PORTS; k++) begin
      prev[k] = rsp_rdata[k*WIDTH +: WIDTH];
      req_valid[k] = op_v[k];
      req_write[k] = op_w[k];
      req_addr[k*AW +: AW] = {(k == 0) ? ROW_W'(row) : ROW_W'(op_rb[k]), COL_W'(op_c[k])};
      req_wdata[k*WIDTH +: WIDTH] = op_d[k];
    end
    exp_c = 0;
    for (int a = 0; a < PORTS; a++)
      for (int b = a + 1; b < PORTS; b++)
        if (op_v[a] && op_v[b] && op_c[a] == op_c[b] && (op_w[a] || op_w[b])) exp_c = 1;
    for (int k = 0; k < PORTS; k++) begin
      known[k] = 1;
      for (int j = 0; j < PORTS; j++)
        if (j != k && op_v[j] && op_w[j] && op_c[j] == op_c[k]) known[k] = 0;
      exp_d[k] = model[row*WPR + op_c[k]];
    end
    for (int k = PORTS - 1; k >= 0; k--)
      if (op_v[k] && op_w[k]) model[row*WPR + op_c[k]] = op_d[k];
    @(posedge clk);
    @(negedge clk);
    check(col_clash == exp_c, "R5", "col_clash", col_clash, exp_c);
    for (int k = 0; k < PORTS; k++) begin
      bit exp_rv;
      exp_rv = op_v[k] && !op_w[k];
      check(rsp_valid[k] == exp_rv, tag, $sformatf("rsp_valid[%0d]", k), rsp_valid[k], exp_rv);
      if (exp_rv && known[k])
        check(rsp_rdata[k*WIDTH +: WIDTH] == exp_d[k], tag, $sformatf("rsp_rdata[%0d]", k),
              rsp_rdata[k*WIDTH +: WIDTH], exp_d[k]);
      else if (!exp_rv)
        check(rsp_rdata[k*WIDTH +: WIDTH] == prev[k], "R8", $sformatf("rsp_rdata[%0d] hold", k),
              rsp_rdata[k*WIDTH +: WIDTH], prev[k]);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    clear_ops();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    check(rsp_valid == '0, "R7", "rsp_valid in reset", rsp_valid, 0);
    check(rsp_rdata == '0, "R7", "rsp_rdata in reset", rsp_rdata, 0);
    check(col_clash == 1'b0, "R7", "col_clash in reset", col_clash, 0);
    rst_n = 1'b1;

    // R3: fill every word, all ports writing distinct columns of one row
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < WPR; c += PORTS) begin
        clear_ops();
        for (int k = 0; k < PORTS; k++) begin
          op_v[k] = (c + k < WPR); op_w[k] = 1; op_c[k] = c + k;
          op_rb[k] = $urandom; op_d[k] = WIDTH'($urandom);
        end
        issue(r, "R3");
      end
    end

    // R1: secondary row bits point elsewhere but are ignored
    for (int c = 0; c < WPR; c++) begin
      clear_ops();
      for (int k = 0; k < PORTS; k++) begin
        op_v[k] = 1; op_c[k] = (c + k) % WPR; op_rb[k] = 200 + k;
      end
      issue(5, "R1");
    end

    // R4: read and write of distinct columns together, then read back (R3)
    clear_ops();
    op_v[0] = 1; op_w[0] = 1; op_c[0] = 2; op_d[0] = 8'hA5;
    op_v[1] = 1; op_c[1] = 3; op_rb[1] = 9;
    issue(7, "R4");
    clear_ops();
    op_v[1] = 1; op_c[1] = 2; op_rb[1] = 3;
    issue(7, "R3");

    // R5: two reads of one column raise no flag and both return the word
    clear_ops();
    op_v[0] = 1; op_c[0] = 6; op_v[1] = 1; op_c[1] = 6;
    issue(11, "R5");

    // R6: two writes of one column, lowest port wins
    clear_ops();
    op_v[0] = 1; op_w[0] = 1; op_c[0] = 4; op_d[0] = 8'h3C;
    op_v[1] = 1; op_w[1] = 1; op_c[1] = 4; op_d[1] = 8'hC3;
    issue(12, "R6");
    clear_ops();
    op_v[0] = 1; op_c[0] = 4;
    issue(12, "R6");

    // R5: read and write of one column, flag set, write still lands
    clear_ops();
    op_v[0] = 1; op_c[0] = 1;
    op_v[1] = 1; op_w[1] = 1; op_c[1] = 1; op_d[1] = 8'h77;
    issue(20, "R5");
    clear_ops();
    op_v[1] = 1; op_c[1] = 1;
    issue(20, "R6");

    // R8: idle cycles keep the last read word
    clear_ops();
    repeat (3) issue(0, "R8");

    // R4: random same-row traffic with natural and forced collisions
    for (int n = 0; n < 4000; n++) begin
      int row;
      row = $urandom_range(0, ROWS - 1);
      clear_ops();
      for (int k = 0; k < PORTS; k++) begin
        op_v[k]  = ($urandom_range(0, 3) != 0);
        op_w[k]  = $urandom_range(0, 1);
        op_c[k]  = (n % 5 == 0) ? 0 : $urandom_range(0, WPR - 1);
        op_rb[k] = $urandom;
        op_d[k]  = WIDTH'($urandom);
      end
      issue(row, "R4");
    end

    finish_run();
  end

endmodule